// File: doc/BRIEF.md
# Device Capability Register Space

This block is the read-mostly register window of a memory-expansion device. A host-side bus adapter presents one request per cycle: a byte address, an access size of 1, 2, 4 or 8 bytes, a write flag and write data. One cycle later the block answers with little-endian read data, zero-extended to 64 bits, or with an error flag if the access was not naturally aligned.

The window has four regions, each placed at a fixed base:

| Region | Address range | Contents |
|---|---|---|
| Capability list | 0x000 to 0x07F | A header, then one entry per region that follows. Software walks it to find the other regions. |
| Status | 0x080 to 0x09F | An availability bitmap with one bit per event log type, and a timestamp. |
| Mailbox | 0x100 to 0x1FF | Not stored here. Each access is passed straight to a separate mailbox block, and its data comes back in the same cycle. |
| Media status | 0x200 to 0x207 | A constant readiness word. |

Addresses outside these regions read as zero.

The device's own logic marks event logs as available or empty through a side port. The host sets the timestamp through another side port. After it is set, the timestamp advances by the clock period in nanoseconds on every cycle.

Top module: `devcap_regspace`

## Requirements
- R1: After reset, every bit of the event availability bitmap reads 0, and the timestamp reads 0.
- R2: An 8-byte read at 0x000 returns the header 64'h0000_0003_0001_0000. Its fields are: bits [15:0] capability id 0, bits [23:16] version 1, bits [47:32] entry count 3.
- R3: Each capability entry is 16 bytes long, and the entries start at 0x010. The first quadword of an entry holds the id in bits [15:0], the version in bits [23:16] and the region base in bits [63:32]. The second quadword holds the region length in bits [31:0]. The entries, in order, are:
  - status: id 1, version 2, base 0x80, length 0x20
  - mailbox: id 2, version 1, base 0x100, length 0x100
  - media status: id 0x4000, version 1, base 0x200, length 8
- R4: A read at 0x200 always returns 64'h14. In that word, bits [3:2] are the media status field, set to 1, and bit 4 is the mailbox-ready flag, set to 1. Writes to this region change nothing.
- R5: A pulse on the event update port with a log index writes the availability value into the bitmap bit of that log. Other bits keep their values. The bitmap reads at 0x080 in bits [NUM_LOGS-1:0], with the upper bits zero.
- R6: The timestamp reads at 0x088. It reads 0 until it is first set. After a set with value V that takes effect at clock edge e, a read captured at edge e+d returns V + d*NS_PER_CLK.
- R7: The size code is 0, 1, 2 or 3, for 1, 2, 4 or 8 bytes. A read of N bytes at address A returns bytes A to A+N-1 of the region, little-endian and zero-extended.
- R8: An access whose address is not a multiple of its size gets rsp_err = 1 and rsp_rdata = 0. Such an access is not passed to the mailbox and changes no state.
- R9: An aligned access inside 0x100 to 0x1FF raises mbx_valid in the same cycle. It presents the offset within that region, the size code, the write flag and the write data. The read response is mbx_rdata masked to the access size.
- R10: Writes to the capability list and the status region are discarded. Later reads return the same values as before the write.
- R11: Each request gets exactly one response, with rsp_valid high, one cycle after the request. Reads outside every region return 0 with rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes |
| req_wdata | input | 64 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | The access was misaligned |
| rsp_rdata | output | 64 | Read data, zero-extended |
| mbx_valid | output | 1 | Access passed to the mailbox block |
| mbx_write | output | 1 | Write flag of the passed access |
| mbx_addr | output | 8 | Offset within the mailbox region |
| mbx_size | output | 2 | Size code of the passed access |
| mbx_wdata | output | 64 | Write data of the passed access |
| mbx_rdata | input | 64 | Read data from the mailbox block, returned in the same cycle |
| evt_upd_valid | input | 1 | Event availability update strobe |
| evt_upd_log | input | clog2(NUM_LOGS) | Index of the event log to update |
| evt_upd_avail | input | 1 | New availability value for that log |
| ts_set_valid | input | 1 | Timestamp set strobe |
| ts_set_value | input | 64 | Timestamp value in nanoseconds |

## Verification
Every quadword of the capability list and the media-status word is read at full width.

Narrow reads at offsets inside a quadword catch lane-shift and masking errors that a full-width read would hide. Reads of 1 byte at 0x002 and 2 bytes at 0x030 are examples.

The event bitmap is driven through set, set and clear sequences on different logs, so a bit that is stuck or written to the wrong position shows up. The timestamp is read before it is set, and then at known cycle distances, which checks both the gate and the step per cycle.

Misaligned reads and writes are sent into every region, including the mailbox region, and the bench checks that none of them reaches the mailbox port. Writes to the read-only regions are each followed by a read-back.

// File: rtl/devcap_pkg.sv
package devcap_pkg;

    // Fixed window layout. The capability list reports these bases, so they are part of the behaviour.
    localparam int CAPS_BASE   = 'h000;
    localparam int CAPS_LEN    = 'h080;
    localparam int STAT_BASE   = 'h080;
    localparam int STAT_LEN    = 'h020;
    localparam int MBOX_BASE   = 'h100;
    localparam int MBOX_LEN    = 'h100;
    localparam int MEDIA_BASE  = 'h200;
    localparam int MEDIA_LEN   = 'h008;
    localparam int MBOX_AW     = $clog2(MBOX_LEN);
    localparam int CAP_ENTRIES = 3;

    // Media status field = 1 in bits [3:2], mailbox ready in bit 4.
    localparam logic [63:0] MEDIA_WORD = 64'h14;

    typedef enum logic [2:0] {
        RG_CAPS,
        RG_STAT,
        RG_MBOX,
        RG_MEDIA,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic [15:0] id;
        logic [7:0]  ver;
        logic [31:0] base;
        logic [31:0] len;
    } cap_entry_t;

    typedef struct packed {
        region_e rg;
        logic    aligned;
    } decode_t;

    function automatic cap_entry_t cap_entry(int k);
        case (k)
            0:       return '{id: 16'h0001, ver: 8'd2, base: 32'(STAT_BASE),  len: 32'(STAT_LEN)};
            1:       return '{id: 16'h0002, ver: 8'd1, base: 32'(MBOX_BASE),  len: 32'(MBOX_LEN)};
            default: return '{id: 16'h4000, ver: 8'd1, base: 32'(MEDIA_BASE), len: 32'(MEDIA_LEN)};
        endcase
    endfunction

    function automatic logic [63:0] caps_header();
        return {16'h0, 16'(CAP_ENTRIES), 8'h0, 8'd1, 16'h0};
    endfunction

    // Quadword q of the capability list: header at 0, entries from quadword 2 on.
    function automatic logic [63:0] caps_qword(logic [3:0] q);
        cap_entry_t e;
        if (q == 4'd0) begin
            return caps_header();
        end
        if (q >= 4'd2 && int'(q) < 2 + 2 * CAP_ENTRIES) begin
            e = cap_entry((int'(q) - 2) / 2);
            if (!q[0]) begin
                return {e.base, 8'h0, e.ver, e.id};
            end
            return {32'h0, e.len};
        end
        return 64'h0;
    endfunction

    function automatic logic [63:0] size_mask(logic [1:0] sz);
        case (sz)
            2'd0:    return 64'h0000_0000_0000_00FF;
            2'd1:    return 64'h0000_0000_0000_FFFF;
            2'd2:    return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/devcap_decode.sv
module devcap_decode
    import devcap_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output decode_t           dec,
    output logic [ADDR_W-1:0] off
);
    logic [31:0] a32;

    assign a32 = 32'(addr);

    always_comb begin
        case (size)
            2'd0:    dec.aligned = 1'b1;
            2'd1:    dec.aligned = (addr[0] == 1'b0);
            2'd2:    dec.aligned = (addr[1:0] == 2'b00);
            default: dec.aligned = (addr[2:0] == 3'b000);
        endcase

        dec.rg = RG_NONE;
        off    = addr;
        if (a32 < 32'(CAPS_BASE + CAPS_LEN)) begin
            dec.rg = RG_CAPS;
            off    = ADDR_W'(a32 - 32'(CAPS_BASE));
        end else if (a32 >= 32'(STAT_BASE) && a32 < 32'(STAT_BASE + STAT_LEN)) begin
            dec.rg = RG_STAT;
            off    = ADDR_W'(a32 - 32'(STAT_BASE));
        end else if (a32 >= 32'(MBOX_BASE) && a32 < 32'(MBOX_BASE + MBOX_LEN)) begin
            dec.rg = RG_MBOX;
            off    = ADDR_W'(a32 - 32'(MBOX_BASE));
        end else if (a32 >= 32'(MEDIA_BASE) && a32 < 32'(MEDIA_BASE + MEDIA_LEN)) begin
            dec.rg = RG_MEDIA;
            off    = ADDR_W'(a32 - 32'(MEDIA_BASE));
        end
    end
endmodule

// File: rtl/devcap_status.sv
module devcap_status #(
    parameter int NUM_LOGS   = 5,
    parameter int NS_PER_CLK = 20,
    localparam int LOG_W     = $clog2(NUM_LOGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_valid,
    input  logic [LOG_W-1:0]    upd_log,
    input  logic                upd_avail,
    input  logic                set_valid,
    input  logic [63:0]         set_value,
    output logic [NUM_LOGS-1:0] evt_bits,
    output logic [63:0]         ts_now
);
    logic armed;

    // One flop per log type, each with its own index match.
    for (genvar i = 0; i < NUM_LOGS; i++) begin : g_log
        always_ff @(posedge clk) begin
            if (rst) begin
                evt_bits[i] <= 1'b0;
            end else if (upd_valid && upd_log == LOG_W'(i)) begin
                evt_bits[i] <= upd_avail;
            end
        end
    end

    // The register runs one step ahead, so a read at edge e+d sees V + d*NS_PER_CLK.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            ts_now <= 64'h0;
        end else if (set_valid) begin
            armed  <= 1'b1;
            ts_now <= set_value + 64'(NS_PER_CLK);
        end else if (armed) begin
            ts_now <= ts_now + 64'(NS_PER_CLK);
        end
    end
endmodule

// File: rtl/devcap_lanes.sv
module devcap_lanes
    import devcap_pkg::*;
(
    input  logic [63:0] qword,
    input  logic [2:0]  byte_off,
    input  logic [1:0]  size,
    output logic [63:0] data
);
    always_comb begin
        data = (qword >> {byte_off, 3'b000}) & size_mask(size);
    end
endmodule

// File: rtl/devcap_regspace.sv
module devcap_regspace
    import devcap_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_LOGS   = 5,
    parameter int NS_PER_CLK = 20
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [1:0]                  req_size,
    input  logic [63:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [63:0]                 rsp_rdata,
    output logic                        mbx_valid,
    output logic                        mbx_write,
    output logic [MBOX_AW-1:0]          mbx_addr,
    output logic [1:0]                  mbx_size,
    output logic [63:0]                 mbx_wdata,
    input  logic [63:0]                 mbx_rdata,
    input  logic                        evt_upd_valid,
    input  logic [$clog2(NUM_LOGS)-1:0] evt_upd_log,
    input  logic                        evt_upd_avail,
    input  logic                        ts_set_valid,
    input  logic [63:0]                 ts_set_value
);
    decode_t             dec;
    logic [ADDR_W-1:0]   off;
    logic [NUM_LOGS-1:0] evt_bits;
    logic [63:0]         ts_now;
    logic [63:0]         local_q;
    logic [63:0]         lane_src;
    logic [2:0]          lane_off;
    logic [63:0]         lane_out;
    logic                unused_hi;

    devcap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec),
        .off  (off)
    );

    devcap_status #(.NUM_LOGS(NUM_LOGS), .NS_PER_CLK(NS_PER_CLK)) u_status (
        .clk       (clk),
        .rst       (rst),
        .upd_valid (evt_upd_valid),
        .upd_log   (evt_upd_log),
        .upd_avail (evt_upd_avail),
        .set_valid (ts_set_valid),
        .set_value (ts_set_value),
        .evt_bits  (evt_bits),
        .ts_now    (ts_now)
    );

    assign unused_hi = ^off[ADDR_W-1:MBOX_AW];

    // Forward aligned mailbox accesses in the same cycle.
    assign mbx_valid = req_valid && dec.aligned && dec.rg == RG_MBOX;
    assign mbx_write = req_write;
    assign mbx_addr  = off[MBOX_AW-1:0];
    assign mbx_size  = req_size;
    assign mbx_wdata = req_wdata;

    // Quadword containing the addressed bytes, for the locally held regions.
    always_comb begin
        case (dec.rg)
            RG_CAPS:  local_q = caps_qword(off[6:3]);
            RG_STAT: begin
                case (off[4:3])
                    2'd0:    local_q = 64'(evt_bits);
                    2'd1:    local_q = ts_now;
                    default: local_q = 64'h0;
                endcase
            end
            RG_MEDIA: local_q = MEDIA_WORD;
            default:  local_q = 64'h0;
        endcase
    end

    // Mailbox data arrives right-justified. Local quadwords need a byte shift.
    always_comb begin
        if (dec.rg == RG_MBOX) begin
            lane_src = mbx_rdata;
            lane_off = 3'd0;
        end else begin
            lane_src = local_q;
            lane_off = off[2:0];
        end
    end

    devcap_lanes u_lanes (
        .qword    (lane_src),
        .byte_off (lane_off),
        .size     (req_size),
        .data     (lane_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 64'h0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !dec.aligned;
            rsp_rdata <= (req_valid && !req_write && dec.aligned) ? lane_out : 64'h0;
        end
    end
endmodule

// File: rtl/devcap_regspace_chk.sv
module devcap_regspace_chk
    import devcap_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              mbx_valid
);
    logic [31:0] a32;
    logic        misal;

    assign a32   = 32'(req_addr);
    assign misal = (a32 & ((32'd1 << req_size) - 32'd1)) != 32'd0;

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R8
    err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == 64'h0));

    // R8
    misalign_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && misal) |=> rsp_err);

    // R9
    mbx_fwd_window_chk: assert property (@(posedge clk) disable iff (rst)
        mbx_valid |-> (req_valid && !misal && a32 >= 32'(MBOX_BASE)
                       && a32 < 32'(MBOX_BASE + MBOX_LEN)));

    // R4
    media_word_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd3 && a32 == 32'(MEDIA_BASE))
        |=> rsp_rdata == 64'h14);

    // R2
    header_word_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd3 && a32 == 32'd0)
        |=> rsp_rdata == 64'h0000_0003_0001_0000);
endmodule

bind devcap_regspace devcap_regspace_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/devcap_regspace_tb_top.sv
module devcap_regspace_tb_top;
    localparam int AW = 12;
    localparam int NL = 5;
    localparam int NS = 20;

    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [1:0]        req_size = 2'd0;
    logic [63:0]       req_wdata = 64'h0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [63:0]       rsp_rdata;
    logic              mbx_valid;
    logic              mbx_write;
    logic [7:0]        mbx_addr;
    logic [1:0]        mbx_size;
    logic [63:0]       mbx_wdata;
    logic [63:0]       mbx_rdata;
    logic              evt_upd_valid = 1'b0;
    logic [2:0]        evt_upd_log = 3'd0;
    logic              evt_upd_avail = 1'b0;
    logic              ts_set_valid = 1'b0;
    logic [63:0]       ts_set_value = 64'h0;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   mbx_cnt = 0;
    logic        last_w;
    logic [7:0]  last_a;
    logic [1:0]  last_s;
    logic [63:0] last_d;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    devcap_regspace #(.ADDR_W(AW), .NUM_LOGS(NL), .NS_PER_CLK(NS)) dut_i (.*);

    // Mailbox stand-in: returns a marker word that carries the offset.
    assign mbx_rdata = 64'hA500_0000_0000_0000 | 64'(mbx_addr);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mbx_valid) begin
            mbx_cnt <= mbx_cnt + 1;
            last_w  <= mbx_write;
            last_a  <= mbx_addr;
            last_s  <= mbx_size;
            last_d  <= mbx_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expectation for every response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected response", {63'h0, rsp_valid}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_rdata == e.data && rsp_err == e.err, e.tag,
                      {rsp_err, rsp_rdata[62:0]}, {e.err, e.data[62:0]});
            end
        end
    end

    // Driver: called at a negedge, holds the request for one cycle.
    task automatic access(input bit wr, input int addr, input int sz, input logic [63:0] wd,
                          input logic [63:0] exp, input bit err, input string tag);
        exp_t e;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_size  = 2'(sz);
        req_wdata = wd;
        e.data = exp;
        e.err  = err;
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input int addr, input int sz, input logic [63:0] exp, input string tag);
        access(1'b0, addr, sz, 64'h0, exp, 1'b0, tag);
    endtask

    task automatic evt(input int lg, input bit av);
        evt_upd_valid = 1'b1;
        evt_upd_log   = 3'(lg);
        evt_upd_avail = av;
        @(negedge clk);
        evt_upd_valid = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int set_edge;
        int mc;
        logic [63:0] tv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rsp_valid == 1'b0, "R11 idle after reset", {63'h0, rsp_valid}, 64'h0);

        // R1 reset values
        rd('h080, 3, 64'h0, "R1 event bitmap after reset");
        rd('h088, 3, 64'h0, "R1/R6 timestamp before set");

        // R2 header, R7 narrow lanes
        rd('h000, 3, 64'h0000_0003_0001_0000, "R2 header");
        rd('h004, 2, 64'h3, "R2/R7 count via 4-byte read");
        rd('h002, 1, 64'h1, "R7 version via 2-byte read");
        rd('h002, 0, 64'h1, "R7 version via 1-byte read");
        rd('h001, 0, 64'h0, "R7 id upper byte");

        // R3 entries
        rd('h010, 3, 64'h0000_0080_0002_0001, "R3 status entry word0");
        rd('h018, 3, 64'h20, "R3 status entry length");
        rd('h020, 3, 64'h0000_0100_0001_0002, "R3 mailbox entry word0");
        rd('h028, 3, 64'h100, "R3 mailbox entry length");
        rd('h030, 3, 64'h0000_0200_0001_4000, "R3 media entry word0");
        rd('h038, 3, 64'h8, "R3 media entry length");
        rd('h030, 1, 64'h4000, "R3/R7 media id 2-byte read");
        rd('h034, 2, 64'h200, "R3/R7 media base 4-byte read");
        rd('h040, 3, 64'h0, "R3 past last entry");

        // R4 media status
        rd('h200, 3, 64'h14, "R4 media word");
        rd('h200, 0, 64'h14, "R4 media word byte read");
        access(1'b1, 'h200, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R4 write ack");
        rd('h200, 3, 64'h14, "R4 media word after write");

        // R10 read-only regions
        access(1'b1, 'h000, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R10 caps write ack");
        rd('h000, 3, 64'h0000_0003_0001_0000, "R10 header after write");
        access(1'b1, 'h080, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R10 status write ack");
        rd('h080, 3, 64'h0, "R10 bitmap after write");
        access(1'b1, 'h088, 3, 64'h1234, 64'h0, 1'b0, "R10 timestamp write ack");
        rd('h088, 3, 64'h0, "R10 timestamp after write");

        // R5 event bitmap
        evt(1, 1'b1);
        evt(3, 1'b1);
        rd('h080, 3, 64'h0A, "R5 logs 1 and 3 set");
        evt(1, 1'b0);
        rd('h080, 3, 64'h08, "R5 log 1 cleared");
        evt(4, 1'b1);
        rd('h080, 0, 64'h18, "R5/R7 byte read of bitmap");
        evt(0, 1'b0);
        rd('h080, 3, 64'h18, "R5 clearing an empty log");

        // R6 timestamp
        tv = 64'h0000_1000_0000_0000;
        ts_set_valid = 1'b1;
        ts_set_value = tv;
        set_edge = cyc + 1;
        @(negedge clk);
        ts_set_valid = 1'b0;
        repeat (4) @(negedge clk);
        rd('h088, 3, tv + 64'((cyc + 1 - set_edge) * NS), "R6 timestamp after set");
        rd('h088, 2, (tv + 64'((cyc + 1 - set_edge) * NS)) & 64'hFFFF_FFFF, "R6/R7 timestamp low half");
        rd('h08C, 2, (tv + 64'((cyc + 1 - set_edge) * NS)) >> 32, "R6/R7 timestamp high half");

        // R8 misaligned
        mc = mbx_cnt;
        access(1'b0, 'h001, 1, 64'h0, 64'h0, 1'b1, "R8 misaligned 2-byte caps");
        access(1'b0, 'h082, 2, 64'h0, 64'h0, 1'b1, "R8 misaligned 4-byte status");
        access(1'b0, 'h104, 3, 64'h0, 64'h0, 1'b1, "R8 misaligned 8-byte mailbox read");
        access(1'b1, 'h101, 1, 64'h55, 64'h0, 1'b1, "R8 misaligned mailbox write");
        @(negedge clk);
        check(mbx_cnt == mc, "R8 nothing forwarded", 64'(mbx_cnt), 64'(mc));
        rd('h080, 3, 64'h18, "R8 bitmap unchanged");

        // R9 mailbox forwarding
        rd('h100, 3, 64'hA500_0000_0000_0000, "R9 mailbox 8-byte read");
        rd('h105, 0, 64'h05, "R9 mailbox byte read masked");
        rd('h104, 2, 64'h04, "R9 mailbox 4-byte read masked");
        access(1'b1, 'h108, 3, 64'hDEAD_BEEF_0BAD_F00D, 64'h0, 1'b0, "R9 mailbox write ack");
        check(last_w == 1'b1 && last_a == 8'h08 && last_s == 2'd3 && last_d == 64'hDEAD_BEEF_0BAD_F00D,
              "R9 forwarded write fields", last_d, 64'hDEAD_BEEF_0BAD_F00D);

        // R11 holes and single-cycle response
        rd('h300, 3, 64'h0, "R11 hole read");
        rd('h0A0, 3, 64'h0, "R11 gap after status region");
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 response lasts one cycle", {63'h0, rsp_valid}, 64'h0);
        check(exp_q.size() == 0, "R11 all responses seen", 64'(exp_q.size()), 64'h0);

        report();
        $finish;
    end
endmodule